// File: doc/BRIEF.md
# Tone Burst Timing Sequencer

The sequencer walks through a small symbol memory, one entry per signalling slot, and drives an external dual-tone generator with a key code and an enable. Each entry is read from the memory and classified as a keypad key, a silent slot or the end of the list. A key slot is made of a silent pause followed by a tone burst. A silent slot is made of a pause followed by a tone interval of the same length during which the generator is kept off. The end code stops the walk and raises a done flag.

All timing is counted in sample ticks, which are one-cycle strobes supplied by the sample clock domain logic. With an 8 kHz tick and the default counts of 400 ticks, the pause and the burst each last 50 ms. A 100 ms slot therefore holds a 50 ms burst, inside the 45 to 55 ms window that telephone keypad signalling allows. A start pulse begins the list at address 0 from the idle or done state. A start pulse that arrives while a list is being played is ignored. If the list holds no end code, the address wraps from the last entry back to 0.

Top module: `burst_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, `tone_en_o`, `done_o` and `mem_rd_o` are 0 and `key_o` is 0.
- R2: A start pulse in the idle or done state clears `done_o`. In the next cycle it drives `mem_rd_o` high with `mem_addr_o` = 0. Read data is taken from `mem_data_i` one cycle after `mem_rd_o` was high.
- R3: A code from 0 to 11 is a key. Its value appears on `key_o` before the burst starts.
- R4: Each burst starts only after exactly `PAUSE_TICKS` ticks have been counted with `tone_en_o` low, following the read of that entry. `tone_en_o` rises in the cycle after the last of those ticks.
- R5: `tone_en_o` stays high for exactly `TONE_TICKS` ticks and then falls. `key_o` does not change while it is high.
- R6: Codes 12, 13 and 14 are silent slots. Each holds `tone_en_o` low for `PAUSE_TICKS` + `TONE_TICKS` ticks and then moves on to the next entry.
- R7: Code 15 ends the list. `done_o` goes high with `tone_en_o` low, and no further reads are issued until the next start.
- R8: A start pulse that arrives while an entry is being read, paused or played has no effect on the address or on the output sequence.
- R9: After each key or silent slot the address steps by one. After entry 255 it wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; begins the list at address 0 |
| tick_i | input | 1 | Sample tick strobe, one cycle wide |
| mem_rd_o | output | 1 | Read request to the symbol memory |
| mem_addr_o | output | ADDR_W | Symbol memory address |
| mem_data_i | input | CODE_W | Symbol code, valid one cycle after the read request |
| key_o | output | CODE_W | Key code for the tone generator |
| tone_en_o | output | 1 | Tone generator enable |
| done_o | output | 1 | High once the end code has been read |

## Verification
A corrupted interval counter shows at the ports within one slot. The number of ticks counted while the enable is high stops matching the burst length, or the ticks counted in a gap before a burst fall outside the bound set by the pause length and the silent slots before it. A wrong control state, or a misread code, shows at the next rising edge of the enable as a key out of order or a missing burst. At the end of the list it shows as a burst count that differs from the keys stored before the end code. An address fault appears when the list wraps, because the burst after the last entry then fails to repeat the first key.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_FETCH = 3'd1,
    S_PAUSE = 3'd2,
    S_TONE  = 3'd3,
    S_DONE  = 3'd4
  } seq_state_t;

  typedef enum logic [1:0] {
    CL_KEY    = 2'd0,
    CL_SILENT = 2'd1,
    CL_END    = 2'd2
  } code_class_t;

endpackage

// File: rtl/bs_classify.sv
module bs_classify
  import burst_seq_pkg::*;
#(
  parameter int CODE_W   = 4,
  parameter int NUM_KEYS = 12,
  parameter int END_CODE = 15
) (
  input  logic [CODE_W-1:0] code_i,
  output code_class_t       class_o
);

  localparam logic [CODE_W-1:0] KEY_LIMIT = CODE_W'(NUM_KEYS);
  localparam logic [CODE_W-1:0] END_VAL   = CODE_W'(END_CODE);

  // the end marker has priority; everything that is neither a key nor the
  // marker is treated as a silent slot
  always_comb begin
    if (code_i == END_VAL)       class_o = CL_END;
    else if (code_i < KEY_LIMIT) class_o = CL_KEY;
    else                         class_o = CL_SILENT;
  end

endmodule

// File: rtl/bs_interval.sv
module bs_interval #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic             expire_o,
  output logic [CNT_W-1:0] count_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                            cnt_q <= '0;
    else if (load_i)                    cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  // the tick that takes the count from one to zero closes the interval
  assign expire_o = tick_i && (cnt_q == CNT_W'(1));
  assign count_o  = cnt_q;

endmodule

// File: rtl/bs_addr.sv
module bs_addr #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] addr_o
);

  always_ff @(posedge clk) begin
    if (rst || clr_i) addr_o <= '0;
    else if (adv_i)   addr_o <= addr_o + 1'b1;  // natural wrap at 2**ADDR_W
  end

endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int CODE_W      = 4,
  parameter int NUM_KEYS    = 12,
  parameter int END_CODE    = 15,
  parameter int PAUSE_TICKS = 400,
  parameter int TONE_TICKS  = 400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              tick_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [CODE_W-1:0] mem_data_i,
  output logic [CODE_W-1:0] key_o,
  output logic              tone_en_o,
  output logic              done_o
);

  localparam int MAX_TICKS = (PAUSE_TICKS > TONE_TICKS) ? PAUSE_TICKS : TONE_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);
  localparam logic [CNT_W-1:0] PAUSE_LD = CNT_W'(PAUSE_TICKS);
  localparam logic [CNT_W-1:0] TONE_LD  = CNT_W'(TONE_TICKS);

  seq_state_t       state;
  logic             fetch_ph;     // 0: request issued, 1: data valid
  logic             slot_is_key;
  code_class_t      code_class;
  logic             expire;
  logic [CNT_W-1:0] cnt;
  logic             cnt_load;
  logic [CNT_W-1:0] cnt_val;
  logic             addr_clr;
  logic             addr_adv;
  logic             can_start;
  logic             decode_now;

  assign can_start  = (state == S_IDLE) || (state == S_DONE);
  assign decode_now = (state == S_FETCH) && fetch_ph;

  bs_classify #(
    .CODE_W  (CODE_W),
    .NUM_KEYS(NUM_KEYS),
    .END_CODE(END_CODE)
  ) u_classify (
    .code_i (mem_data_i),
    .class_o(code_class)
  );

  // a single down-counter is shared by the pause and the tone interval
  always_comb begin
    cnt_load = 1'b0;
    cnt_val  = PAUSE_LD;
    if (decode_now && code_class != CL_END) begin
      cnt_load = 1'b1;
      cnt_val  = PAUSE_LD;
    end else if (state == S_PAUSE && expire) begin
      cnt_load = 1'b1;
      cnt_val  = TONE_LD;
    end
  end

  bs_interval #(
    .CNT_W(CNT_W)
  ) u_interval (
    .clk       (clk),
    .rst       (rst),
    .load_i    (cnt_load),
    .load_val_i(cnt_val),
    .tick_i    (tick_i),
    .expire_o  (expire),
    .count_o   (cnt)
  );

  assign addr_clr = can_start && start_i;
  assign addr_adv = (state == S_TONE) && expire;

  bs_addr #(
    .ADDR_W(ADDR_W)
  ) u_addr (
    .clk   (clk),
    .rst   (rst),
    .clr_i (addr_clr),
    .adv_i (addr_adv),
    .addr_o(mem_addr_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      fetch_ph    <= 1'b0;
      slot_is_key <= 1'b0;
      mem_rd_o    <= 1'b0;
      key_o       <= '0;
      tone_en_o   <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE, S_DONE: begin
          if (start_i) begin
            state    <= S_FETCH;
            fetch_ph <= 1'b0;
            mem_rd_o <= 1'b1;
            done_o   <= 1'b0;
          end
        end
        S_FETCH: begin
          if (!fetch_ph) begin
            mem_rd_o <= 1'b0;
            fetch_ph <= 1'b1;
          end else begin
            fetch_ph <= 1'b0;
            if (code_class == CL_END) begin
              state  <= S_DONE;
              done_o <= 1'b1;
            end else begin
              state       <= S_PAUSE;
              slot_is_key <= (code_class == CL_KEY);
              if (code_class == CL_KEY) key_o <= mem_data_i;
            end
          end
        end
        S_PAUSE: begin
          if (expire) begin
            state     <= S_TONE;
            tone_en_o <= slot_is_key;
          end
        end
        S_TONE: begin
          if (expire) begin
            state     <= S_FETCH;
            fetch_ph  <= 1'b0;
            mem_rd_o  <= 1'b1;
            tone_en_o <= 1'b0;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int CODE_W    = 4,
  parameter int CNT_W     = 9,
  parameter int MAX_TICKS = 400
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              tick_i,
  input logic              mem_rd_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [CODE_W-1:0] key_o,
  input logic              tone_en_o,
  input logic              done_o,
  input seq_state_t        st,
  input logic [CNT_W-1:0]  cnt
);

  logic busy;
  assign busy = (st == S_FETCH) || (st == S_PAUSE) || (st == S_TONE);

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!tone_en_o && !done_o && !mem_rd_o && key_o == '0)); // R1

  AST_START_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!busy && start_i) |=> (mem_rd_o && mem_addr_o == '0 && !done_o)); // R2

  AST_BURST_AFTER_PAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(tone_en_o) |-> ($past(tick_i) && $past(st) == S_PAUSE)); // R4

  AST_KEY_STABLE: assert property (@(posedge clk) disable iff (rst)
    (tone_en_o && $past(tone_en_o)) |-> $stable(key_o)); // R5

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(MAX_TICKS)); // R5

  AST_ENABLE_IN_TONE: assert property (@(posedge clk) disable iff (rst)
    tone_en_o |-> (st == S_TONE)); // R6

  AST_DONE_SILENT: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!tone_en_o && !mem_rd_o)); // R7

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> done_o); // R7

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && start_i && !tick_i) |=> $stable(mem_addr_o)); // R8

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    ($rose(mem_rd_o) && $past(st) == S_TONE) |->
      (mem_addr_o == ADDR_W'($past(mem_addr_o) + 1'b1))); // R9

  AST_STATE_FLAGS: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tone_en_o, done_o, mem_rd_o})); // R7

endmodule

bind burst_seq burst_seq_chk #(
  .ADDR_W   (ADDR_W),
  .CODE_W   (CODE_W),
  .CNT_W    (CNT_W),
  .MAX_TICKS(MAX_TICKS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start_i   (start_i),
  .tick_i    (tick_i),
  .mem_rd_o  (mem_rd_o),
  .mem_addr_o(mem_addr_o),
  .key_o     (key_o),
  .tone_en_o (tone_en_o),
  .done_o    (done_o),
  .st        (state),
  .cnt       (cnt)
);

// File: tb/burst_seq_tb.sv
`timescale 1ns/1ps
module burst_seq_tb;

  localparam int P = 6;
  localparam int T = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic       tick_i = 1'b0;
  logic       tick_on = 1'b0;
  logic       mem_rd_o;
  logic [7:0] mem_addr_o;
  logic [3:0] mem_q = '0;
  logic [3:0] key_o;
  logic       tone_en_o;
  logic       done_o;

  logic [3:0] mem [256];

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  logic [3:0] exp_key [300];
  int         exp_sil [300];
  int         n_exp;
  int         nb;
  int         on_ticks;
  int         gap;
  logic       prev_en = 1'b0;
  logic       mon_en = 1'b0;
  int         reads_in_done;

  always #10 clk = ~clk;

  burst_seq #(.PAUSE_TICKS(P), .TONE_TICKS(T)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .tick_i(tick_i),
    .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .mem_data_i(mem_q),
    .key_o(key_o), .tone_en_o(tone_en_o), .done_o(done_o));

  always @(posedge clk) if (mem_rd_o) mem_q <= mem[mem_addr_o];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int gap_min(input int s);
    return s * (P + T) + P;
  endfunction

  // expected bursts from the memory contents: keys 0..11, 15 ends, others silent
  task automatic build_expect();
    int s = 0;
    n_exp = 0;
    for (int a = 0; a < 256; a++) begin
      if (mem[a] == 4'd15) break;
      if (mem[a] < 4'd12) begin
        exp_key[n_exp] = mem[a];
        exp_sil[n_exp] = s;
        n_exp++;
        s = 0;
      end else s++;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      tick_i = tick_on && ($urandom_range(0, 1) == 1);
    end
  end

  always @(negedge clk) begin
    if (mon_en) begin
      if (tone_en_o && !prev_en) begin
        if (nb < n_exp) begin
          chk(key_o == exp_key[nb], "R3 key order", int'(key_o), int'(exp_key[nb]));
          chk(gap >= gap_min(exp_sil[nb]) &&
              gap <= gap_min(exp_sil[nb]) + 2 * (exp_sil[nb] + 1) + 1,
              (exp_sil[nb] > 0) ? "R6 silent gap" : "R4 pause gap",
              gap, gap_min(exp_sil[nb]));
        end else chk(1'b0, "R7 extra burst", nb + 1, n_exp);
        nb++;
        on_ticks = 0;
      end
      if (!tone_en_o && prev_en) begin
        chk(on_ticks == T, "R5 tone ticks", on_ticks, T);
        gap = 0;
      end
      if (tick_i && tone_en_o) on_ticks++;
      if (tick_i && !tone_en_o && !done_o) gap++;
      if (done_o && mem_rd_o) reads_in_done++;
      prev_en = tone_en_o;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        n_fail++;
        n_chk++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  task automatic run_seq(input bit poke);
    int w;
    build_expect();
    nb = 0; gap = 0; on_ticks = 0; reads_in_done = 0;
    mon_en = 1'b1;
    @(posedge clk); #2;
    start_i = 1'b1;
    @(posedge clk); #2;
    start_i = 1'b0;
    @(negedge clk);
    chk(mem_rd_o && mem_addr_o == 8'd0, "R2 first read at 0", int'(mem_addr_o), 0);
    chk(!done_o, "R2 done cleared", int'(done_o), 0);
    if (poke && n_exp > 0) begin
      w = 0;
      while (!tone_en_o && w < 20000) begin @(negedge clk); w++; end
      @(posedge clk); #2;
      start_i = 1'b1;
      @(posedge clk); #2;
      start_i = 1'b0;
    end
    w = 0;
    while (!done_o && w < 60000) begin @(negedge clk); w++; end
    chk(done_o, "R7 done raised", int'(done_o), 1);
    chk(!tone_en_o, "R7 enable low at done", int'(tone_en_o), 0);
    repeat (30) @(negedge clk);
    chk(nb == n_exp, poke ? "R8 bursts with busy start" : "R7 burst count", nb, n_exp);
    chk(done_o && reads_in_done == 0, "R7 no reads after end", reads_in_done, 0);
    mon_en = 1'b0;
    prev_en = 1'b0;
  endtask

  task automatic fill(input int code);
    for (int a = 0; a < 256; a++) mem[a] = 4'(code);
  endtask

  initial begin
    void'($urandom(32'h1F2E3D4C));
    fill(15);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!tone_en_o && !done_o && !mem_rd_o && key_o == 4'd0, "R1 reset outputs",
        int'({tone_en_o, done_o, mem_rd_o}), 0);
    @(posedge clk); #2;
    rst = 1'b0;
    tick_on = 1'b1;
    @(negedge clk);
    chk(!tone_en_o && !done_o && !mem_rd_o, "R1 idle after reset",
        int'({tone_en_o, done_o, mem_rd_o}), 0);

    // directed: immediate end marker
    fill(15);
    run_seq(1'b0);

    // directed: leading and trailing silence, all three silent codes
    fill(15);
    mem[0] = 4'd12; mem[1] = 4'd13; mem[2] = 4'd5; mem[3] = 4'd14;
    mem[4] = 4'd11; mem[5] = 4'd0; mem[6] = 4'd12;
    run_seq(1'b0);

    // directed: start while busy
    fill(15);
    mem[0] = 4'd9; mem[1] = 4'd2; mem[2] = 4'd12; mem[3] = 4'd7;
    run_seq(1'b1);

    // random lists
    for (int k = 0; k < 12; k++) begin
      int len;
      fill(15);
      len = $urandom_range(3, 12);
      for (int a = 0; a < len; a++) begin
        if ($urandom_range(0, 3) == 0) mem[a] = 4'(12 + $urandom_range(0, 2));
        else mem[a] = 4'($urandom_range(0, 11));
      end
      run_seq(k == 5);
    end

    // directed: wrap past entry 255 with no end marker
    fill(12);
    mem[0] = 4'd3; mem[255] = 4'd7;
    exp_key[0] = 4'd3; exp_sil[0] = 0;
    exp_key[1] = 4'd7; exp_sil[1] = 254;
    exp_key[2] = 4'd3; exp_sil[2] = 0;
    n_exp = 3;
    nb = 0; gap = 0; on_ticks = 0;
    mon_en = 1'b1;
    @(posedge clk); #2;
    start_i = 1'b1;
    @(posedge clk); #2;
    start_i = 1'b0;
    begin
      int w = 0;
      while (nb < 3 && w < 40000) begin @(negedge clk); w++; end
    end
    chk(nb == 3, "R9 wrap repeats first key", nb, 3);
    mon_en = 1'b0;
    @(posedge clk); #2;
    rst = 1'b1;
    @(posedge clk); #2;
    @(negedge clk);
    chk(!tone_en_o && !done_o && !mem_rd_o && key_o == 4'd0, "R1 reset mid-list",
        int'(key_o), 0);
    rst = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule